// File: doc/BRIEF.md
# Three-Phase No-Load Detector

This block watches the per-phase power samples of a three-phase energy meter and decides, for each phase, whether that phase is sitting at or below a programmable no-load level. Two detector channels run side by side and never interact. One works on total active power and the other on apparent power. Each phase that a channel places in no-load gets an inhibit output. The downstream energy accumulator and pulse generator use it to stop integrating that phase, so a meter with voltage applied and no load current does not creep.

Each channel has a signed 24-bit threshold. The threshold is sign-extended to the 28-bit datapath, and a negative value switches the channel off. The power samples are evaluated only on a sample-valid strobe. A channel's sticky status bit is set whenever any of its phases enters or leaves no-load. The status bits are cleared by writing 1. A mask register decides which status bits pull the shared active-low interrupt. Threshold values are scaled against the full-scale power of 0x1FF6A6B.

Top module: `noload_monitor`

## Requirements
- R1: On a strobe, a phase of a channel goes into no-load when the magnitude of its 28-bit signed power is less than or equal to that channel's non-negative threshold. Otherwise the phase is out of no-load. The two channels are evaluated independently of each other.
- R2: Each threshold holds 24 bits, taken from write data bits 23:0. It is sign-extended to 28 bits for comparison. It reads back as that 28-bit sign-extended value, with bits 31:28 read as zero.
- R3: A threshold with bit 23 set disables its channel: at the next strobe every phase of that channel is reported out of no-load.
- R4: The inhibit outputs and the phase register give the no-load state. In the phase register, the active channel uses bits 2:0 and the apparent channel uses bits 8:6, with phase A in the lowest bit of each group. The state takes the value evaluated at a strobe edge and shows it from the following cycle.
- R5: Power inputs are looked at only in cycles where sample_vld is high. Without a strobe, no state bit or status bit changes.
- R6: Status bit 0 (active channel) or bit 2 (apparent channel) is set on the same edge that any phase of that channel changes state. A strobe that changes nothing does not set it.
- R7: A status bit is cleared only by a write of 1 to its position in the status register. Writing 0 leaves it as it is.
- R8: irq_n is low exactly while some status bit is set and the mask bit at the same position (bit 0 or bit 2 of the mask register) is 1. Only bits 0 and 2 of the mask are stored.
- R9: When a state change and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R10: After reset, all state, status and mask bits are 0, irq_n is high, and both thresholds hold 0x800000, so both channels are disabled.
- R11: The full-scale sample ±0x1FF6A6B, and also the most negative 28-bit sample, are never in no-load, even at the largest threshold 0x7FFFFF.
- R12: The register addresses are: 0 for the active threshold, 1 for the apparent threshold, 2 for status, 3 for mask, and 4 for the phase register, which is read-only. Reads of addresses 5 to 7 return 0. Reads are combinational from bus_addr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_vld | input | 1 | Power samples valid this cycle |
| act_pwr | input | 84 | Active power per phase, signed 28-bit, phase A in bits 27:0 |
| app_pwr | input | 84 | Apparent power per phase, same packing |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational |
| inhib_act | output | 3 | Active-energy inhibit per phase |
| inhib_app | output | 3 | Apparent-energy inhibit per phase |
| irq_n | output | 1 | Interrupt, active low |

## Verification
Every result of a strobe or a register write comes from one register stage. A stimulus driven at a falling edge is captured at the next rising edge, and state, status and irq_n are due from that edge on. The bench therefore samples them at the falling edge that follows. Register reads are combinational, so they are checked one time step after bus_addr is set. The cases where nothing should happen, such as a power change without a strobe or a write of 0 to status, are observed over several cycles through the outputs and through read-back.

// File: rtl/noload_pkg.sv
package noload_pkg;

   localparam int NL_CHANNELS = 2;
   localparam int CH_ACT = 0;
   localparam int CH_APP = 1;

   localparam int STS_ACT_BIT = 0;
   localparam int STS_APP_BIT = 2;

   localparam logic [27:0] NL_FULL_SCALE = 28'h1FF6A6B;

   typedef enum logic [2:0] {
      RA_ACT_THR = 3'd0,
      RA_APP_THR = 3'd1,
      RA_STATUS  = 3'd2,
      RA_MASK    = 3'd3,
      RA_PHASE   = 3'd4
   } reg_addr_e;

   function automatic int sts_pos(input int ch);
      return (ch == CH_ACT) ? STS_ACT_BIT : STS_APP_BIT;
   endfunction

endpackage

// File: rtl/noload_cmp.sv
module noload_cmp #(
   parameter int PWR_W = 28
) (
   input  logic [PWR_W-1:0] pwr,
   input  logic [PWR_W-1:0] thr_ext,
   output logic             in_nl
);

   localparam int MAG_W = PWR_W + 1;

   logic [MAG_W-1:0] mag;
   logic             pwr_neg;
   logic             thr_neg;

   assign pwr_neg = pwr[PWR_W-1];
   assign thr_neg = thr_ext[PWR_W-1];

   // One extra bit keeps the magnitude of the most negative sample exact.
   always_comb begin
      if (pwr_neg) mag = {1'b0, ~pwr} + MAG_W'(1);
      else         mag = {1'b0, pwr};
   end

   assign in_nl = !thr_neg && (mag <= {1'b0, thr_ext});

endmodule

// File: rtl/noload_chan.sv
module noload_chan #(
   parameter int NUM_PH = 3,
   parameter int PWR_W  = 28
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sample_vld,
   input  logic [NUM_PH*PWR_W-1:0] pwr,
   input  logic [PWR_W-1:0]        thr_ext,
   output logic [NUM_PH-1:0]       state_q,
   output logic                    change
);

   logic [NUM_PH-1:0] nl_now;

   for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
      noload_cmp #(.PWR_W(PWR_W)) u_cmp (
         .pwr     (pwr[p*PWR_W +: PWR_W]),
         .thr_ext (thr_ext),
         .in_nl   (nl_now[p])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          state_q <= '0;
      else if (sample_vld) state_q <= nl_now;
   end

   assign change = sample_vld && (nl_now != state_q);

endmodule

// File: rtl/noload_regs.sv
module noload_regs
   import noload_pkg::*;
#(
   parameter int NUM_PH  = 3,
   parameter int PWR_W   = 28,
   parameter int THR_W   = 24,
   parameter int BUS_W   = 32,
   parameter int ADDR_W  = 3,
   parameter int APP_OFS = 6
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                bus_wr,
   input  logic [ADDR_W-1:0]                   bus_addr,
   input  logic [BUS_W-1:0]                    bus_wdata,
   output logic [BUS_W-1:0]                    bus_rdata,
   input  logic [NL_CHANNELS-1:0]              evt,
   input  logic [NUM_PH-1:0]                   act_state,
   input  logic [NUM_PH-1:0]                   app_state,
   output logic [NL_CHANNELS-1:0][THR_W-1:0]   thr_q,
   output logic [NL_CHANNELS-1:0][PWR_W-1:0]   thr_ext,
   output logic [NL_CHANNELS-1:0]              sts_q,
   output logic [NL_CHANNELS-1:0]              msk_q,
   output logic                                irq_n
);

   localparam logic [THR_W-1:0] THR_RST = {1'b1, {(THR_W-1){1'b0}}};
   localparam int               EXT_W   = PWR_W - THR_W;

   logic [NL_CHANNELS-1:0] clr;
   logic                   unused_wdata;

   assign unused_wdata = ^bus_wdata;

   // Sign extension: a plain copy when the widths agree.
   for (genvar c = 0; c < NL_CHANNELS; c++) begin : g_ext
      if (EXT_W == 0) begin : g_same
         assign thr_ext[c] = thr_q[c];
      end else begin : g_wide
         assign thr_ext[c] = {{EXT_W{thr_q[c][THR_W-1]}}, thr_q[c]};
      end
      assign clr[c] = bus_wr && (bus_addr == ADDR_W'(RA_STATUS))
                      && bus_wdata[sts_pos(c)];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_q <= {NL_CHANNELS{THR_RST}};
         msk_q <= '0;
         sts_q <= '0;
      end else begin
         if (bus_wr) begin
            case (bus_addr)
               ADDR_W'(RA_ACT_THR): thr_q[CH_ACT] <= bus_wdata[THR_W-1:0];
               ADDR_W'(RA_APP_THR): thr_q[CH_APP] <= bus_wdata[THR_W-1:0];
               ADDR_W'(RA_MASK): begin
                  msk_q[CH_ACT] <= bus_wdata[STS_ACT_BIT];
                  msk_q[CH_APP] <= bus_wdata[STS_APP_BIT];
               end
               default: ;
            endcase
         end
         // A new event outranks a clear in the same cycle.
         for (int c = 0; c < NL_CHANNELS; c++)
            sts_q[c] <= evt[c] | (sts_q[c] & ~clr[c]);
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(RA_ACT_THR): bus_rdata = BUS_W'(thr_ext[CH_ACT]);
         ADDR_W'(RA_APP_THR): bus_rdata = BUS_W'(thr_ext[CH_APP]);
         ADDR_W'(RA_STATUS): begin
            bus_rdata[STS_ACT_BIT] = sts_q[CH_ACT];
            bus_rdata[STS_APP_BIT] = sts_q[CH_APP];
         end
         ADDR_W'(RA_MASK): begin
            bus_rdata[STS_ACT_BIT] = msk_q[CH_ACT];
            bus_rdata[STS_APP_BIT] = msk_q[CH_APP];
         end
         ADDR_W'(RA_PHASE): begin
            bus_rdata[NUM_PH-1:0]         = act_state;
            bus_rdata[APP_OFS +: NUM_PH]  = app_state;
         end
         default: bus_rdata = '0;
      endcase
   end

   assign irq_n = ~|(sts_q & msk_q);

endmodule

// File: rtl/noload_monitor.sv
module noload_monitor
   import noload_pkg::*;
#(
   parameter int NUM_PH  = 3,
   parameter int PWR_W   = 28,
   parameter int THR_W   = 24,
   parameter int BUS_W   = 32,
   parameter int ADDR_W  = 3,
   parameter int APP_OFS = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sample_vld,
   input  logic [NUM_PH*PWR_W-1:0] act_pwr,
   input  logic [NUM_PH*PWR_W-1:0] app_pwr,
   input  logic                    bus_wr,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [BUS_W-1:0]        bus_wdata,
   output logic [BUS_W-1:0]        bus_rdata,
   output logic [NUM_PH-1:0]       inhib_act,
   output logic [NUM_PH-1:0]       inhib_app,
   output logic                    irq_n
);

   if (THR_W > PWR_W) begin : g_chk_thr
      $error("threshold wider than datapath");
   end
   if (PWR_W > BUS_W) begin : g_chk_bus
      $error("datapath wider than register bus");
   end
   if (APP_OFS < NUM_PH || APP_OFS + NUM_PH > BUS_W) begin : g_chk_ofs
      $error("phase register fields overlap or overflow");
   end
   if (ADDR_W < 3) begin : g_chk_addr
      $error("address too narrow for register map");
   end

   logic [NUM_PH*PWR_W-1:0]              ch_pwr   [NL_CHANNELS];
   logic [NUM_PH-1:0]                    ch_state [NL_CHANNELS];
   logic [NL_CHANNELS-1:0]               ch_evt;
   logic [NL_CHANNELS-1:0][THR_W-1:0]    thr_q;
   logic [NL_CHANNELS-1:0][PWR_W-1:0]    thr_ext;
   logic [NL_CHANNELS-1:0]               sts_q;
   logic [NL_CHANNELS-1:0]               msk_q;

   assign ch_pwr[CH_ACT] = act_pwr;
   assign ch_pwr[CH_APP] = app_pwr;

   for (genvar c = 0; c < NL_CHANNELS; c++) begin : g_ch
      noload_chan #(.NUM_PH(NUM_PH), .PWR_W(PWR_W)) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .sample_vld (sample_vld),
         .pwr        (ch_pwr[c]),
         .thr_ext    (thr_ext[c]),
         .state_q    (ch_state[c]),
         .change     (ch_evt[c])
      );
   end

   noload_regs #(
      .NUM_PH(NUM_PH), .PWR_W(PWR_W), .THR_W(THR_W),
      .BUS_W(BUS_W), .ADDR_W(ADDR_W), .APP_OFS(APP_OFS)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .evt       (ch_evt),
      .act_state (ch_state[CH_ACT]),
      .app_state (ch_state[CH_APP]),
      .thr_q     (thr_q),
      .thr_ext   (thr_ext),
      .sts_q     (sts_q),
      .msk_q     (msk_q),
      .irq_n     (irq_n)
   );

   assign inhib_act = ch_state[CH_ACT];
   assign inhib_app = ch_state[CH_APP];

endmodule

// File: rtl/noload_monitor_chk.sv
module noload_monitor_chk
   import noload_pkg::*;
#(
   parameter int NUM_PH = 3,
   parameter int THR_W  = 24,
   parameter int BUS_W  = 32,
   parameter int ADDR_W = 3
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             sample_vld,
   input logic                             bus_wr,
   input logic [ADDR_W-1:0]                bus_addr,
   input logic [BUS_W-1:0]                 bus_wdata,
   input logic [NUM_PH-1:0]                inhib_act,
   input logic [NUM_PH-1:0]                inhib_app,
   input logic                             irq_n,
   input logic [NL_CHANNELS-1:0][THR_W-1:0] thr_q,
   input logic [NL_CHANNELS-1:0]           sts_q,
   input logic [NL_CHANNELS-1:0]           msk_q
);

   a_r3_act_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_vld && thr_q[CH_ACT][THR_W-1]) |=> (inhib_act == '0));

   a_r3_app_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_vld && thr_q[CH_APP][THR_W-1]) |=> (inhib_app == '0));

   a_r5_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sample_vld) |-> ($stable(inhib_act) && $stable(inhib_app)));

   a_r6_act_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (inhib_act != $past(inhib_act)) |-> sts_q[CH_ACT]);

   a_r6_app_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (inhib_app != $past(inhib_app)) |-> sts_q[CH_APP]);

   a_r7_act_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sts_q[CH_ACT]) |->
         $past(bus_wr && (bus_addr == ADDR_W'(RA_STATUS)) && bus_wdata[STS_ACT_BIT]));

   a_r7_app_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sts_q[CH_APP]) |->
         $past(bus_wr && (bus_addr == ADDR_W'(RA_STATUS)) && bus_wdata[STS_APP_BIT]));

   a_r8_irq_follows_regs: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(irq_n) |-> (!$stable(sts_q) || !$stable(msk_q)));

endmodule

bind noload_monitor noload_monitor_chk #(
   .NUM_PH(NUM_PH), .THR_W(THR_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sample_vld (sample_vld),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .inhib_act  (inhib_act),
   .inhib_app  (inhib_app),
   .irq_n      (irq_n),
   .thr_q      (thr_q),
   .sts_q      (sts_q),
   .msk_q      (msk_q)
);

// File: tb/noload_monitor_bench.sv
`timescale 1ns/1ps
module noload_monitor_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sample_vld = 1'b0;
   logic [83:0] act_pwr = '0;
   logic [83:0] app_pwr = '0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [2:0]  inhib_act;
   logic [2:0]  inhib_app;
   logic        irq_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   noload_monitor u_noload_monitor (
      .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld),
      .act_pwr(act_pwr), .app_pwr(app_pwr),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .inhib_act(inhib_act), .inhib_app(inhib_app),
      .irq_n(irq_n)
   );

   localparam logic [27:0] FS  = 28'h1FF6A6B;
   localparam logic [27:0] MIN = 28'h8000000;

   function automatic logic [27:0] neg(input logic [27:0] v);
      return ~v + 28'd1;
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic set_pwr(input logic [27:0] a0, a1, a2, p0, p1, p2);
      act_pwr = {a2, a1, a0};
      app_pwr = {p2, p1, p0};
   endtask

   task automatic sample(input logic [27:0] a0, a1, a2, p0, p1, p2);
      @(negedge clk);
      set_pwr(a0, a1, a2, p0, p1, p2);
      sample_vld = 1'b1;
      @(negedge clk);
      sample_vld = 1'b0;
   endtask

   task automatic chk_rd(input string req, input logic [2:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(req, d, exp);
   endtask

   task automatic t_reset;
      chk("R10 irq_n", {31'd0, irq_n}, 32'd1);
      chk("R10 inhib", {26'd0, inhib_app, inhib_act}, 32'd0);
      chk_rd("R10 status", 3'd2, 32'd0);
      chk_rd("R10 mask", 3'd3, 32'd0);
      chk_rd("R10 phase", 3'd4, 32'd0);
      chk_rd("R2 act thr reset", 3'd0, 32'h0F800000);
      chk_rd("R2 app thr reset", 3'd1, 32'h0F800000);
      sample(28'd0, 28'd0, 28'd0, 28'd0, 28'd0, 28'd0);
      chk("R3 disabled at zero power", {26'd0, inhib_app, inhib_act}, 32'd0);
      chk_rd("R6 no event", 3'd2, 32'd0);
   endtask

   task automatic t_basic;
      wr(3'd0, 32'd1000);
      wr(3'd1, 32'd2000);
      chk_rd("R2 readback", 3'd0, 32'd1000);
      sample(28'd500, neg(28'd1000), 28'd1001, 28'd3000, neg(28'd2000), 28'd0);
      chk("R1 act phases", {29'd0, inhib_act}, 32'b011);
      chk("R1 app phases", {29'd0, inhib_app}, 32'b110);
      chk_rd("R4 phase reg", 3'd4, 32'h183);
      chk_rd("R6 both set", 3'd2, 32'h5);
      chk("R8 masked", {31'd0, irq_n}, 32'd1);
   endtask

   task automatic t_irq;
      wr(3'd3, 32'h1);
      chk("R8 irq on", {31'd0, irq_n}, 32'd0);
      wr(3'd2, 32'h0);
      chk_rd("R7 write zero", 3'd2, 32'h5);
      wr(3'd2, 32'h4);
      chk_rd("R7 clear app only", 3'd2, 32'h1);
      chk("R8 still on", {31'd0, irq_n}, 32'd0);
      wr(3'd2, 32'h1);
      chk_rd("R7 clear act", 3'd2, 32'h0);
      chk("R8 irq off", {31'd0, irq_n}, 32'd1);
      wr(3'd3, 32'hFFFFFFFF);
      chk_rd("R12 mask bits", 3'd3, 32'h5);
   endtask

   task automatic t_hold;
      @(negedge clk);
      set_pwr(28'd0, 28'd0, 28'd0, 28'd0, 28'd0, 28'd0);
      repeat (3) @(negedge clk);
      chk("R5 act hold", {29'd0, inhib_act}, 32'b011);
      chk("R5 app hold", {29'd0, inhib_app}, 32'b110);
      chk_rd("R5 status hold", 3'd2, 32'h0);
      sample(28'd500, neg(28'd1000), 28'd1001, 28'd3000, neg(28'd2000), 28'd0);
      chk_rd("R6 same values", 3'd2, 32'h0);
      chk("R8 quiet", {31'd0, irq_n}, 32'd1);
   endtask

   task automatic t_exit;
      sample(28'd1500, neg(28'd1000), 28'd1001, 28'd3000, neg(28'd2000), 28'd0);
      chk("R1 exit A", {29'd0, inhib_act}, 32'b010);
      chk_rd("R6 exit act", 3'd2, 32'h1);
      chk("R8 irq exit", {31'd0, irq_n}, 32'd0);
      wr(3'd2, 32'h5);
   endtask

   task automatic t_disable;
      wr(3'd0, 32'h00FFFFFF);
      chk_rd("R2 negative readback", 3'd0, 32'h0FFFFFFF);
      sample(28'd1500, neg(28'd1000), 28'd1001, 28'd3000, neg(28'd2000), 28'd0);
      chk("R3 act off", {29'd0, inhib_act}, 32'b000);
      chk("R1 app independent", {29'd0, inhib_app}, 32'b110);
      chk_rd("R6 disable exit", 3'd2, 32'h1);
      wr(3'd2, 32'h5);
   endtask

   task automatic t_fullscale;
      wr(3'd0, 32'h007FFFFF);
      sample(28'h07FFFFF, neg(FS), MIN, 28'd3000, neg(28'd2000), 28'd0);
      chk("R11 full scale", {29'd0, inhib_act}, 32'b001);
      chk_rd("R6 enter", 3'd2, 32'h1);
      wr(3'd2, 32'h5);
      sample(neg(28'h07FFFFF), FS, 28'h0800000, 28'd3000, neg(28'd2000), 28'd0);
      chk("R11 edge values", {29'd0, inhib_act}, 32'b001);
      chk_rd("R6 unchanged", 3'd2, 32'h0);
   endtask

   task automatic t_priority;
      sample(neg(28'h07FFFFF), FS, 28'h0800000, 28'd0, 28'd0, 28'd0);
      chk_rd("R6 app only", 3'd2, 32'h4);
      @(negedge clk);
      set_pwr(28'd1, 28'd1, 28'd1, 28'd0, 28'd0, 28'd0);
      sample_vld = 1'b1;
      bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 32'h5;
      @(negedge clk);
      sample_vld = 1'b0; bus_wr = 1'b0;
      chk_rd("R9 set wins", 3'd2, 32'h1);
      chk("R4 all act", {29'd0, inhib_act}, 32'b111);
   endtask

   task automatic t_map;
      chk_rd("R12 addr7", 3'd7, 32'h0);
      chk_rd("R12 addr5", 3'd5, 32'h0);
      wr(3'd4, 32'h0);
      chk_rd("R12 phase read-only", 3'd4, 32'h1C7);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_basic;
      t_irq;
      t_hold;
      t_exit;
      t_disable;
      t_fullscale;
      t_priority;
      t_map;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule